// File: doc/BRIEF.md
# Buffered-Compare Timer/Event Counter

This block is a 16-bit up-counter behind a small register port. The counter advances either on one of eight internal tick rates, each derived by dividing the system clock by a power of two, or on a selected transition of an external event line. A run bit in the control register starts the counter and stops it. While the counter is stopped it rests at all-ones, but a read of the count returns zero. Because of this idle value, the first step after starting takes the count to zero.

There are two compare channels. Software writes a visible compare register for each channel. The match logic uses a hidden shadow copy of that register, which software can neither read nor write. When the counter is stopped, a write reaches the shadow copy at once. When the counter is running, the shadow copy reloads only when the count rolls over from all-ones to zero. Each channel raises a one-cycle interrupt pulse when the counter steps onto its shadow value.

Top module: `tmr_evt_top`

## Requirements
- R1: After reset, all four register addresses read 0, and both interrupt outputs are low.
- R2: While run (control bit 0) is 0, the count register (address 3) reads 0 and the internal count rests at FFFFH. The first count step after run is set takes the count to 0000H.
- R3: With internal source selected (control bit 1 = 0), the select field (bits 4:2, value k) produces one count step every 2^k clocks. The divider restarts from zero whenever run is 0, so the first step comes 2^k clocks after the enabling write takes effect.
- R4: With external source selected (control bit 1 = 1), the event input passes through a two-stage synchronizer. The edge field (bits 6:5) selects which transitions count: 0 = none, 1 = rising, 2 = falling, 3 = both. A counted transition shows in the count three clocks after the input changes.
- R5: A compare write (address 1 for channel 0, address 2 for channel 1) made while run is 0 loads that channel's shadow value in the same clock.
- R6: A compare write made while running leaves the shadow value unchanged until the next rollover from FFFFH to 0000H. A write in the rollover clock itself is the value that takes effect.
- R7: Each interrupt output (bit 0 for channel 0, bit 1 for channel 1) is high for exactly one clock, the clock in which the count first holds that channel's shadow value after a count step.
- R8: Reading a compare address returns the last value written there, not the shadow value.
- R9: The control register (address 0) reads back the written run, source, select and edge fields in bits 6:0, with upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1-2 compare, 3 read-only count |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational from the read address |
| evt_i | input | 1 | External event input, asynchronous |
| irq_o | output | 2 | Per-channel compare-match pulses |

## Verification
The risky collision is a compare write landing in the same clock as the counter rolling over from FFFFH to 0000H. At that moment the shadow reload and the register write both act on one channel. The bench reads the count until it shows FFFEH, then times a channel-1 write so that it is latched on the rollover edge. It then confirms that the interrupt fires at the newly written value in the very next count period. A per-cycle reference model, built from the requirements, judges the same event along with the random traffic around it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W  = 3;
  localparam int N_SEL  = 1 << SEL_W;
  localparam int CTRL_W = 4 + SEL_W;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // packed MSB first: mode[6:5] sel[4:2] ext[1] run[0]
  typedef struct packed {
    edge_mode_e       mode;
    logic [SEL_W-1:0] sel;
    logic             ext;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int N_SEL = 8,
  localparam int PRE_W = (N_SEL > 1) ? N_SEL - 1 : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [N_SEL-1:0] tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k < N_SEL; k++) begin : g_tick
    assign tick_o[k] = &pre_q[k-1:0];
  end

  AST_PRE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0)) else $error("prescaler not cleared"); // R3
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  edge_mode_e mode_i,
  output logic       edge_o
);
  logic [2:0] sync_q;  // [0],[1] synchronizer, [2] previous level

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], evt_i};
  end

  logic rise, fall;
  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  AST_EDGE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_OFF) |-> !edge_o) else $error("edge in off mode"); // R4
  AST_RISE_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && mode_i == EDGE_RISE) |=> sync_q[2]) else $error("rise edge at low level"); // R4
endmodule

// File: rtl/tmr_cmp_ch.sv
module tmr_cmp_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             run_nxt_i,
  input  logic             step_i,
  input  logic             wrap_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_q, cmp_d, buf_q, buf_d;
  logic             irq_q;

  assign cmp_d = wr_i ? wr_data_i : cmp_q;
  // stopped: write goes straight through; running: reload only on rollover
  assign buf_d = ((wr_i && !run_i) || wrap_i) ? cmp_d : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      buf_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      buf_q <= buf_d;
      irq_q <= step_i && run_nxt_i && (cnt_nxt_i == buf_d);
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(buf_q)) else $error("shadow changed mid-period"); // R6
  AST_BUF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !run_i) |=> (buf_q == cmp_q)) else $error("stopped write missed shadow"); // R5
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_i == buf_q)) else $error("irq without match"); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> !$past(irq_q) || !$stable(cnt_i)) else $error("irq held"); // R7
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CMP = 2,
  localparam int AW = $clog2(N_CMP + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             evt_i,
  output logic [N_CMP-1:0] irq_o
);
  localparam logic [AW-1:0] A_CTRL = '0;
  localparam logic [AW-1:0] A_CNT  = AW'(N_CMP + 1);

  ctrl_t            ctrl_q, ctrl_d;
  logic             wr_ctrl;
  logic [N_SEL-1:0] tick;
  logic             ext_edge, step, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_val [N_CMP];

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign ctrl_d  = wr_ctrl ? ctrl_t'(wr_data_i[CTRL_W-1:0]) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  tmr_presc #(.N_SEL(N_SEL)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .tick_o (tick)
  );

  tmr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .mode_i (ctrl_q.mode),
    .edge_o (ext_edge)
  );

  assign step = ctrl_q.run && (ctrl_q.ext ? ext_edge : tick[ctrl_q.sel]);
  assign wrap = step && (&cnt_q);

  always_comb begin
    if (!ctrl_d.run) cnt_d = '1;
    else if (step)   cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_ch
    tmr_cmp_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (ctrl_q.run),
      .run_nxt_i (ctrl_d.run),
      .step_i    (step),
      .wrap_i    (wrap),
      .wr_i      (wr_en_i && (wr_addr_i == AW'(k + 1))),
      .wr_data_i (wr_data_i),
      .cnt_i     (cnt_q),
      .cnt_nxt_i (cnt_d),
      .cmp_o     (cmp_val[k]),
      .irq_o     (irq_o[k])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL)     rd_data_o = CNT_W'(ctrl_q);
    else if (rd_addr_i == A_CNT) rd_data_o = ctrl_q.run ? cnt_q : '0;
    else begin
      for (int k = 0; k < N_CMP; k++)
        if (rd_addr_i == AW'(k + 1)) rd_data_o = cmp_val[k];
    end
  end

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |-> (cnt_q == '1)) else $error("stopped count not idle"); // R2
  AST_RD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && rd_addr_i == A_CNT) |-> (rd_data_o == '0)) else $error("stopped read nonzero"); // R2
  AST_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (&cnt_q) && ctrl_d.run) |=> (cnt_q == '0)) else $error("rollover not zero"); // R2
  AST_NO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && !step && ctrl_d.run) |=> $stable(cnt_q)) else $error("count moved without step"); // R3
endmodule

// File: tb/sim_tmr_evt_top.sv
module sim_tmr_evt_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        evt = 1'b0;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R3";

  tmr_evt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_i(evt), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic        m_run, m_ext;
  logic [2:0]  m_sel;
  logic [1:0]  m_mode;
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [2];
  logic [15:0] m_buf [2];
  logic [1:0]  m_irq;
  logic [6:0]  m_pre;
  logic [2:0]  m_sy;

  always @(posedge clk or negedge rst_n) begin : model
    logic        n_run, tk, ev, stp, wrp;
    logic [15:0] n_cnt, n_cmp, n_buf;
    logic [6:0]  msk;
    if (!rst_n) begin
      m_run = 0; m_ext = 0; m_sel = 0; m_mode = 0; m_cnt = 16'hFFFF;
      m_cmp[0] = 0; m_cmp[1] = 0; m_buf[0] = 0; m_buf[1] = 0;
      m_irq = 0; m_pre = 0; m_sy = 0;
    end else begin
      n_run = (wr_en && wr_addr == 0) ? wr_data[0] : m_run;
      msk = (7'd1 << m_sel) - 7'd1;
      tk  = (m_pre & msk) == msk;
      case (m_mode)
        2'd1: ev = m_sy[1] && !m_sy[2];
        2'd2: ev = !m_sy[1] && m_sy[2];
        2'd3: ev = m_sy[1] != m_sy[2];
        default: ev = 1'b0;
      endcase
      stp = m_run && (m_ext ? ev : tk);
      wrp = stp && m_cnt == 16'hFFFF;
      n_cnt = !n_run ? 16'hFFFF : (stp ? m_cnt + 16'd1 : m_cnt);
      for (int c = 0; c < 2; c++) begin
        n_cmp = (wr_en && wr_addr == 2'(c + 1)) ? wr_data : m_cmp[c];
        n_buf = ((wr_en && wr_addr == 2'(c + 1) && !m_run) || wrp) ? n_cmp : m_buf[c];
        m_irq[c] = stp && n_run && n_cnt == n_buf;
        m_cmp[c] = n_cmp;
        m_buf[c] = n_buf;
      end
      m_pre = m_run ? m_pre + 7'd1 : 7'd0;
      m_sy  = {m_sy[1:0], evt};
      if (wr_en && wr_addr == 0) begin
        m_ext = wr_data[1]; m_sel = wr_data[4:2]; m_mode = wr_data[6:5];
      end
      m_run = n_run;
      m_cnt = n_cnt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R7 irq", {14'd0, irq}, {14'd0, m_irq});
      case (rd_addr)
        2'd0: chk("R9 ctrl read", rd_data, {9'd0, m_mode, m_sel, m_ext, m_run});
        2'd1: chk("R8 cmp0 read", rd_data, m_cmp[0]);
        2'd2: chk("R8 cmp1 read", rd_data, m_cmp[1]);
        default: chk({cur_req, " count read"}, rd_data, m_run ? m_cnt : 16'd0);
      endcase
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [15:0] exp);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  int p0, p1;

  task automatic count_irq(int n);
    p0 = 0; p1 = 0;
    repeat (n) begin
      @(negedge clk);
      p0 += int'(irq[0]);
      p1 += int'(irq[1]);
    end
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : drive
    cyc(3);
    rst_n = 1; #1;
    // R1 reset state
    rd_chk("R1 ctrl", 0, 0); rd_chk("R1 cmp0", 1, 0);
    rd_chk("R1 cmp1", 2, 0); rd_chk("R1 cnt", 3, 0);
    chk("R1 irq", {14'd0, irq}, 0);
    // R9 control readback without running
    wr(0, 16'h0066);
    rd_chk("R9 ctrl fields", 0, 16'h0066);
    // R5 stopped writes, R8 register read
    wr(0, 0);
    wr(1, 16'd5); wr(2, 16'd9);
    rd_chk("R8 cmp0 value", 1, 16'd5);
    rd_chk("R2 stopped read", 3, 0);
    // R2/R7 start at sel 0
    rd_addr = 3;
    wr(0, 16'h0001);
    @(negedge clk); @(negedge clk);
    chk("R2 first step zero", rd_data, 0);
    #1;
    count_irq(20);
    chk("R7 ch0 one pulse", 16'(p0), 1);
    chk("R7 ch1 one pulse", 16'(p1), 1);
    // R3 divide by 4
    wr(0, 0);
    wr(0, 16'h0009);
    repeat (4) @(negedge clk);
    chk("R3 before first tick", rd_data, 16'hFFFF);
    @(negedge clk);
    chk("R3 first tick", rd_data, 0);
    repeat (4) @(negedge clk);
    chk("R3 second tick", rd_data, 1);
    #1;
    // R4 external edges
    wr(0, 0);
    wr(0, 16'h0023);
    evt = 1; cyc(5);
    @(negedge clk); chk("R4 rise counted", rd_data, 0); #1;
    evt = 0; cyc(5);
    @(negedge clk); chk("R4 fall ignored", rd_data, 0); #1;
    wr(0, 16'h0003);
    evt = 1; cyc(4); evt = 0; cyc(4);
    @(negedge clk); chk("R4 none mode", rd_data, 0); #1;
    wr(0, 16'h0063);
    evt = 1; cyc(4); evt = 0; cyc(4);
    @(negedge clk); chk("R4 both edges", rd_data, 2); #1;
    wr(0, 16'h0043);
    evt = 1; cyc(4); evt = 0;
    cyc(3);
    @(negedge clk); chk("R4 fall edge", rd_data, 3); #1;
    // random traffic
    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rd_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) evt = ~evt;
      if (r < 4) begin
        wr_en = 1; wr_addr = 0;
        wr_data = {9'd0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 2)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) != 0)};
      end else if (r < 14) begin
        wr_en = 1; wr_addr = 2'($urandom_range(1, 2));
        wr_data = 16'($urandom_range(0, 63));
      end else wr_en = 0;
      cyc(1);
    end
    wr_en = 0;
    // R6 deferred reload and rollover collision
    cur_req = "R6";
    wr(0, 0);
    wr(1, 16'h0030); wr(2, 16'h0100);
    rd_addr = 3;
    wr(0, 16'h0001);
    cyc(12);
    wr(1, 16'h0020);
    count_irq(80);
    chk("R6 old shadow hit", 16'(p0), 1);
    rd_addr = 1;
    @(negedge clk); chk("R8 new reg value", rd_data, 16'h0020); #1;
    rd_addr = 3;
    while (1) begin
      @(negedge clk);
      if (rd_data == 16'hFFFE) break;
    end
    #1;
    wr(2, 16'h0007);
    count_irq(60);
    chk("R6 reload at rollover ch0", 16'(p0), 1);
    chk("R6 collision write ch1", 16'(p1), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
  end
endmodule